// File: doc/BRIEF.md
# Register Power-State Controller

This block keeps a power state for every architectural register in one register file bank. One state entry covers a warp's register across all of its lanes. The state is off (contents lost), sleep (contents kept, wake needed) or on. Instructions carry power hints for up to two source registers and one destination register. Source hints arrive from the operand-read stage once the operands have been read. The destination hint arrives from write-back once the result is written. Any further source operands of the same instruction can be put to sleep through a mask. The block drives a sleep enable and an off enable for each register.

The issue stage presents a candidate instruction as a warp plus read and write register masks. The block answers at once whether every named register is on. Registers that are not on start waking: a sleeping register is on one cycle later, and an off register is on two cycles later. Until then the warp cannot issue, and the scheduler may pick another warp. A read of an off register raises an error flag. A write to an off register wakes it without error. Warps are allocated into the on state and released into the off state. Three counters record register-cycles spent in each state, for leakage accounting.

Top module: `rps_top`

## Requirements
- R1: After reset every register is off (offEn high, sleepEn low), all three counters are zero, and qryReady is 1 for empty masks.
- R2: allocValid sets the registers of allocWarp selected by allocMask to on at the next edge. releaseValid sets every register of releaseWarp to off at the next edge, and wins over an allocation to the same warp in the same cycle.
- R3: Hint codes are 2'b00 off, 2'b01 sleep, 2'b10 on; 2'b11 is reserved and leaves the state unchanged. Off shows as offEn=1 and sleepEn=0, sleep as sleepEn=1 and offEn=0, on as both 0. sleepEn and offEn are never high together.
- R4: A read-stage hint updates register rdRegN of rdWarp at the next edge when rdValid and rdUseN are high. Every register set in rdExtraMask goes to sleep.
- R5: When a write-back hint and a read-stage hint name the same register in the same cycle, the write-back hint decides the state.
- R6: qryReady is combinational and is 1 exactly when every register of qryWarp selected by qryReadMask or qryWriteMask is on.
- R7: A query with qryValid that names a sleeping register makes it on after one edge, so qryReady rises in the next cycle.
- R8: A query that names an off register makes it on after two edges. In between, the register shows sleepEn=1 and offEn=0.
- R9: offReadErr is high when qryValid is high and qryReadMask selects an off register. Selecting an off register through qryWriteMask wakes it without raising offReadErr.
- R10: At each edge onCycles, sleepCycles and offCycles grow by the number of registers that were on (waking included), sleeping and off during the cycle just ended.
- R11: Register r of warp w is entry w*REGS_PER_WARP+r of sleepEn and offEn. A command for one warp leaves the entries of every other warp unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Allocate registers to a warp |
| allocWarp | input | WARP_W | Warp being allocated |
| allocMask | input | REGS_PER_WARP | Registers to turn on |
| releaseValid | input | 1 | Release all registers of a warp |
| releaseWarp | input | WARP_W | Warp being released |
| rdValid | input | 1 | Operand-read hints valid |
| rdWarp | input | WARP_W | Warp of the read-stage instruction |
| rdReg0 | input | REG_W | First source register |
| rdHint0 | input | 2 | Hint for first source |
| rdUse0 | input | 1 | First source slot used |
| rdReg1 | input | REG_W | Second source register |
| rdHint1 | input | 2 | Hint for second source |
| rdUse1 | input | 1 | Second source slot used |
| rdExtraMask | input | REGS_PER_WARP | Further source registers, put to sleep |
| wbValid | input | 1 | Write-back hint valid |
| wbWarp | input | WARP_W | Warp of the written register |
| wbReg | input | REG_W | Destination register |
| wbHint | input | 2 | Hint for destination |
| qryValid | input | 1 | Issue query valid, starts wakes |
| qryWarp | input | WARP_W | Candidate warp |
| qryReadMask | input | REGS_PER_WARP | Registers the candidate reads |
| qryWriteMask | input | REGS_PER_WARP | Registers the candidate writes |
| qryReady | output | 1 | All named registers are on |
| offReadErr | output | 1 | Query reads an off register |
| sleepEn | output | NREG | Per-register sleep enable |
| offEn | output | NREG | Per-register off enable |
| onCycles | output | CNT_W | Register-cycles on or waking |
| sleepCycles | output | CNT_W | Register-cycles asleep |
| offCycles | output | CNT_W | Register-cycles off |

## Verification
qryReady and offReadErr are combinational, so the bench checks them about 1 ns after driving the query. That is before any edge. Allocation, release and hints change sleepEn and offEn after one edge, and the bench checks them at the next falling edge. A wake from sleep shows in the cycle after the query. A wake from off shows one cycle later still, and the bench checks the waking state in between. Counter deltas are taken between two falling edges that a known number of rising edges apart, while the states do not change.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    PWR_OFF   = 2'b00,
    PWR_SLEEP = 2'b01,
    PWR_ON    = 2'b10,
    PWR_WAKE  = 2'b11
  } pwrState_t;

  // per-register command from control to datapath
  typedef struct packed {
    logic goOff;
    logic goSleep;
    logic goOn;
    logic wake;
  } regStrobe_t;

  function automatic regStrobe_t hintStrobe(input logic [1:0] hint);
    regStrobe_t s;
    s = '0;
    case (hint)
      2'b00:   s.goOff = 1'b1;
      2'b01:   s.goSleep = 1'b1;
      2'b10:   s.goOn = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rps_ctrl.sv
module rps_ctrl
  import rps_pkg::*;
#(
  parameter int NUM_WARPS     = 4,
  parameter int REGS_PER_WARP = 8,
  localparam int NREG   = NUM_WARPS * REGS_PER_WARP,
  localparam int WARP_W = $clog2(NUM_WARPS),
  localparam int REG_W  = $clog2(REGS_PER_WARP)
) (
  input  logic                     allocValid,
  input  logic [WARP_W-1:0]        allocWarp,
  input  logic [REGS_PER_WARP-1:0] allocMask,
  input  logic                     releaseValid,
  input  logic [WARP_W-1:0]        releaseWarp,
  input  logic                     rdValid,
  input  logic [WARP_W-1:0]        rdWarp,
  input  logic [REG_W-1:0]         rdReg0,
  input  logic [1:0]               rdHint0,
  input  logic                     rdUse0,
  input  logic [REG_W-1:0]         rdReg1,
  input  logic [1:0]               rdHint1,
  input  logic                     rdUse1,
  input  logic [REGS_PER_WARP-1:0] rdExtraMask,
  input  logic                     wbValid,
  input  logic [WARP_W-1:0]        wbWarp,
  input  logic [REG_W-1:0]         wbReg,
  input  logic [1:0]               wbHint,
  input  logic                     qryValid,
  input  logic [WARP_W-1:0]        qryWarp,
  input  logic [REGS_PER_WARP-1:0] qryReadMask,
  input  logic [REGS_PER_WARP-1:0] qryWriteMask,
  input  logic [NREG-1:0]          onVec,
  input  logic [NREG-1:0]          offVec,
  input  logic [NREG-1:0]          wakeVec,
  output regStrobe_t               strb [NREG],
  output logic                     qryReady,
  output logic                     offReadErr
);
  logic [NREG-1:0] needVec;
  logic [NREG-1:0] readVec;

  for (genvar g = 0; g < NREG; g++) begin : gReg
    localparam int W = g / REGS_PER_WARP;
    localparam int R = g % REGS_PER_WARP;
    logic qrySel, relHit, alcHit, wbHit, rd0Hit, rd1Hit, extraHit;
    regStrobe_t nxt;

    assign qrySel   = (qryWarp == WARP_W'(W));
    assign needVec[g] = qrySel && (qryReadMask[R] || qryWriteMask[R]);
    assign readVec[g] = qrySel && qryReadMask[R];
    assign relHit   = releaseValid && (releaseWarp == WARP_W'(W));
    assign alcHit   = allocValid && (allocWarp == WARP_W'(W)) && allocMask[R];
    assign wbHit    = wbValid && (wbWarp == WARP_W'(W)) && (wbReg == REG_W'(R)) && (wbHint != 2'b11);
    assign rd0Hit   = rdValid && rdUse0 && (rdWarp == WARP_W'(W)) && (rdReg0 == REG_W'(R)) && (rdHint0 != 2'b11);
    assign rd1Hit   = rdValid && rdUse1 && (rdWarp == WARP_W'(W)) && (rdReg1 == REG_W'(R)) && (rdHint1 != 2'b11);
    assign extraHit = rdValid && (rdWarp == WARP_W'(W)) && rdExtraMask[R];

    // priority: release, allocate, write-back, read stage, wake start
    always_comb begin
      nxt = '0;
      if (relHit)        nxt.goOff = 1'b1;
      else if (alcHit)   nxt.goOn = 1'b1;
      else if (wbHit)    nxt = hintStrobe(wbHint);
      else if (rd1Hit)   nxt = hintStrobe(rdHint1);
      else if (rd0Hit)   nxt = hintStrobe(rdHint0);
      else if (extraHit) nxt.goSleep = 1'b1;
      else if (qryValid && needVec[g] && !onVec[g] && !wakeVec[g]) nxt.wake = 1'b1;
    end
    assign strb[g] = nxt;
  end

  assign qryReady   = ((needVec & ~onVec) == '0);
  assign offReadErr = qryValid && ((readVec & offVec) != '0);
endmodule

// File: rtl/rps_datapath.sv
module rps_datapath
  import rps_pkg::*;
#(
  parameter int NREG      = 32,
  parameter int SLEEP_LAT = 1,
  parameter int OFF_LAT   = 2,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb [NREG],
  output logic [NREG-1:0]  onVec,
  output logic [NREG-1:0]  offVec,
  output logic [NREG-1:0]  wakeVec,
  output logic [NREG-1:0]  sleepEn,
  output logic [NREG-1:0]  offEn,
  output logic [CNT_W-1:0] onCycles,
  output logic [CNT_W-1:0] sleepCycles,
  output logic [CNT_W-1:0] offCycles
);
  localparam int MAX_LAT = (SLEEP_LAT > OFF_LAT) ? SLEEP_LAT : OFF_LAT;
  localparam int CW      = $clog2(MAX_LAT + 1) + 1;
  localparam logic [CW-1:0] SL_LOAD  = CW'((SLEEP_LAT >= 2) ? SLEEP_LAT - 2 : 0);
  localparam logic [CW-1:0] OFF_LOAD = CW'((OFF_LAT >= 2) ? OFF_LAT - 2 : 0);

  logic [NREG-1:0] sleepVec;

  for (genvar g = 0; g < NREG; g++) begin : gCell
    pwrState_t stQ;
    logic [CW-1:0] cntQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ  <= PWR_OFF;
        cntQ <= '0;
      end else if (strb[g].goOff) begin
        stQ <= PWR_OFF;
      end else if (strb[g].goSleep) begin
        stQ <= PWR_SLEEP;
      end else if (strb[g].goOn) begin
        stQ <= PWR_ON;
      end else if (strb[g].wake) begin
        if (stQ == PWR_SLEEP) begin
          stQ  <= (SLEEP_LAT <= 1) ? PWR_ON : PWR_WAKE;
          cntQ <= SL_LOAD;
        end else begin
          stQ  <= (OFF_LAT <= 1) ? PWR_ON : PWR_WAKE;
          cntQ <= OFF_LOAD;
        end
      end else if (stQ == PWR_WAKE) begin
        if (cntQ == '0) stQ <= PWR_ON;
        else            cntQ <= cntQ - 1'b1;
      end
    end

    assign onVec[g]    = (stQ == PWR_ON);
    assign offVec[g]   = (stQ == PWR_OFF);
    assign wakeVec[g]  = (stQ == PWR_WAKE);
    assign sleepVec[g] = (stQ == PWR_SLEEP);
    assign sleepEn[g]  = (stQ == PWR_SLEEP) || (stQ == PWR_WAKE);
    assign offEn[g]    = (stQ == PWR_OFF);
  end

  function automatic logic [CNT_W-1:0] popCount(input logic [NREG-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NREG; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCycles    <= '0;
      sleepCycles <= '0;
      offCycles   <= '0;
    end else begin
      onCycles    <= onCycles + popCount(onVec | wakeVec);
      sleepCycles <= sleepCycles + popCount(sleepVec);
      offCycles   <= offCycles + popCount(offVec);
    end
  end
endmodule

// File: rtl/rps_top.sv
module rps_top
  import rps_pkg::*;
#(
  parameter int NUM_WARPS     = 4,
  parameter int REGS_PER_WARP = 8,
  parameter int SLEEP_LAT     = 1,
  parameter int OFF_LAT       = 2,
  parameter int CNT_W         = 32,
  localparam int NREG   = NUM_WARPS * REGS_PER_WARP,
  localparam int WARP_W = $clog2(NUM_WARPS),
  localparam int REG_W  = $clog2(REGS_PER_WARP)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     allocValid,
  input  logic [WARP_W-1:0]        allocWarp,
  input  logic [REGS_PER_WARP-1:0] allocMask,
  input  logic                     releaseValid,
  input  logic [WARP_W-1:0]        releaseWarp,
  input  logic                     rdValid,
  input  logic [WARP_W-1:0]        rdWarp,
  input  logic [REG_W-1:0]         rdReg0,
  input  logic [1:0]               rdHint0,
  input  logic                     rdUse0,
  input  logic [REG_W-1:0]         rdReg1,
  input  logic [1:0]               rdHint1,
  input  logic                     rdUse1,
  input  logic [REGS_PER_WARP-1:0] rdExtraMask,
  input  logic                     wbValid,
  input  logic [WARP_W-1:0]        wbWarp,
  input  logic [REG_W-1:0]         wbReg,
  input  logic [1:0]               wbHint,
  input  logic                     qryValid,
  input  logic [WARP_W-1:0]        qryWarp,
  input  logic [REGS_PER_WARP-1:0] qryReadMask,
  input  logic [REGS_PER_WARP-1:0] qryWriteMask,
  output logic                     qryReady,
  output logic                     offReadErr,
  output logic [NREG-1:0]          sleepEn,
  output logic [NREG-1:0]          offEn,
  output logic [CNT_W-1:0]         onCycles,
  output logic [CNT_W-1:0]         sleepCycles,
  output logic [CNT_W-1:0]         offCycles
);
  regStrobe_t      strb [NREG];
  logic [NREG-1:0] onVec, offVec, wakeVec;

  rps_ctrl #(.NUM_WARPS(NUM_WARPS), .REGS_PER_WARP(REGS_PER_WARP)) u_ctrl (
    .allocValid(allocValid), .allocWarp(allocWarp), .allocMask(allocMask),
    .releaseValid(releaseValid), .releaseWarp(releaseWarp),
    .rdValid(rdValid), .rdWarp(rdWarp),
    .rdReg0(rdReg0), .rdHint0(rdHint0), .rdUse0(rdUse0),
    .rdReg1(rdReg1), .rdHint1(rdHint1), .rdUse1(rdUse1),
    .rdExtraMask(rdExtraMask),
    .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg), .wbHint(wbHint),
    .qryValid(qryValid), .qryWarp(qryWarp),
    .qryReadMask(qryReadMask), .qryWriteMask(qryWriteMask),
    .onVec(onVec), .offVec(offVec), .wakeVec(wakeVec),
    .strb(strb), .qryReady(qryReady), .offReadErr(offReadErr)
  );

  rps_datapath #(.NREG(NREG), .SLEEP_LAT(SLEEP_LAT), .OFF_LAT(OFF_LAT), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .onVec(onVec), .offVec(offVec), .wakeVec(wakeVec),
    .sleepEn(sleepEn), .offEn(offEn),
    .onCycles(onCycles), .sleepCycles(sleepCycles), .offCycles(offCycles)
  );
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int NUM_WARPS     = 4,
  parameter int REGS_PER_WARP = 8,
  parameter int SLEEP_LAT     = 1,
  parameter int OFF_LAT       = 2,
  parameter int CNT_W         = 32,
  localparam int NREG   = NUM_WARPS * REGS_PER_WARP,
  localparam int WARP_W = $clog2(NUM_WARPS)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     allocValid,
  input logic                     releaseValid,
  input logic [WARP_W-1:0]        releaseWarp,
  input logic                     rdValid,
  input logic                     wbValid,
  input logic                     qryValid,
  input logic [WARP_W-1:0]        qryWarp,
  input logic [REGS_PER_WARP-1:0] qryReadMask,
  input logic [REGS_PER_WARP-1:0] qryWriteMask,
  input logic                     qryReady,
  input logic                     offReadErr,
  input logic [NREG-1:0]          sleepEn,
  input logic [NREG-1:0]          offEn,
  input logic [CNT_W-1:0]         onCycles,
  input logic [CNT_W-1:0]         sleepCycles,
  input logic [CNT_W-1:0]         offCycles
);
  logic [REGS_PER_WARP-1:0] selSleep, selOff, need;
  logic [CNT_W-1:0] total;
  logic armed;

  assign selSleep = sleepEn[qryWarp*REGS_PER_WARP +: REGS_PER_WARP];
  assign selOff   = offEn[qryWarp*REGS_PER_WARP +: REGS_PER_WARP];
  assign need     = qryReadMask | qryWriteMask;
  assign total    = onCycles + sleepCycles + offCycles;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_enable_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sleepEn & offEn) == '0);

  assert_ready_awake_R6: assert property (@(posedge clk) disable iff (!rstN)
    qryReady |-> (((selSleep | selOff) & need) == '0));

  assert_err_off_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    offReadErr |-> (qryValid && ((selOff & qryReadMask) != '0)));

  assert_release_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    releaseValid |=> (&offEn[$past(releaseWarp)*REGS_PER_WARP +: REGS_PER_WARP]));

  assert_count_total_R10: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((total - $past(total)) == CNT_W'(NREG)));

  if (SLEEP_LAT == 1 && OFF_LAT <= 2) begin : gWake
    assert_sleep_wake_R7: assert property (@(posedge clk) disable iff (!rstN)
      (qryValid && !qryReady && ((selOff & need) == '0) &&
       !releaseValid && !allocValid && !rdValid && !wbValid)
      |=> (qryReady || !$stable(qryWarp) || !$stable(qryReadMask) || !$stable(qryWriteMask)));
  end
endmodule

bind rps_top rps_checker #(
  .NUM_WARPS(NUM_WARPS), .REGS_PER_WARP(REGS_PER_WARP),
  .SLEEP_LAT(SLEEP_LAT), .OFF_LAT(OFF_LAT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .allocValid(allocValid),
  .releaseValid(releaseValid), .releaseWarp(releaseWarp),
  .rdValid(rdValid), .wbValid(wbValid),
  .qryValid(qryValid), .qryWarp(qryWarp),
  .qryReadMask(qryReadMask), .qryWriteMask(qryWriteMask),
  .qryReady(qryReady), .offReadErr(offReadErr),
  .sleepEn(sleepEn), .offEn(offEn),
  .onCycles(onCycles), .sleepCycles(sleepCycles), .offCycles(offCycles)
);

// File: tb/sim_rps_top.sv
module sim_rps_top;
  localparam int NW = 4, RPW = 8, NREG = 32, CW = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, releaseValid = 0, rdValid = 0, rdUse0 = 0, rdUse1 = 0, wbValid = 0, qryValid = 0;
  logic [1:0] allocWarp = 0, releaseWarp = 0, rdWarp = 0, wbWarp = 0, qryWarp = 0;
  logic [RPW-1:0] allocMask = 0, rdExtraMask = 0, qryReadMask = 0, qryWriteMask = 0;
  logic [2:0] rdReg0 = 0, rdReg1 = 0, wbReg = 0;
  logic [1:0] rdHint0 = 0, rdHint1 = 0, wbHint = 0;
  logic qryReady, offReadErr;
  logic [NREG-1:0] sleepEn, offEn;
  logic [CW-1:0] onCycles, sleepCycles, offCycles;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rps_top u0 (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    allocValid = 0; releaseValid = 0; rdValid = 0; rdUse0 = 0; rdUse1 = 0;
    rdExtraMask = 0; wbValid = 0; qryValid = 0; qryReadMask = 0; qryWriteMask = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1", "offEn", offEn, {NREG{1'b1}});
    chk("R1", "sleepEn", sleepEn, 0);
    chk("R1", "counters", onCycles | sleepCycles | offCycles, 0);
    chk("R1", "ready empty", qryReady, 1);
  endtask

  task automatic testAlloc();
    allocValid = 1; allocWarp = 1; allocMask = 8'h0F;
    step(); idle();
    chk("R2", "warp1 off", offEn[15:8], 8'hF0);
    chk("R2", "warp1 sleep", sleepEn[15:8], 0);
    chk("R11", "other warps", {offEn[31:16], offEn[7:0]}, 24'hFFFFFF);
  endtask

  task automatic testReadHints();
    rdValid = 1; rdWarp = 1; rdUse0 = 1; rdReg0 = 0; rdHint0 = 2'b01;
    rdUse1 = 1; rdReg1 = 1; rdHint1 = 2'b00; rdExtraMask = 8'h04;
    step(); idle();
    chk("R4", "sleep slot0/extra", sleepEn[11:8], 4'b0101);
    chk("R4", "off slot1", offEn[11:8], 4'b0010);
    chk("R11", "warp0 untouched", offEn[7:0], 8'hFF);
    rdValid = 1; rdWarp = 1; rdUse0 = 1; rdReg0 = 3; rdHint0 = 2'b11;
    step(); idle();
    chk("R3", "reserved hint keeps on", {sleepEn[11], offEn[11]}, 2'b00);
  endtask

  task automatic testConflict();
    rdValid = 1; rdWarp = 1; rdUse0 = 1; rdReg0 = 3; rdHint0 = 2'b00;
    wbValid = 1; wbWarp = 1; wbReg = 3; wbHint = 2'b01;
    step(); idle();
    chk("R5", "wb wins", {sleepEn[11], offEn[11]}, 2'b10);
    wbValid = 1; wbWarp = 1; wbReg = 3; wbHint = 2'b10;
    step(); idle();
    chk("R3", "on hint", {sleepEn[11], offEn[11]}, 2'b00);
  endtask

  task automatic testSleepWake();
    qryValid = 1; qryWarp = 1; qryReadMask = 8'h01;
    #1;
    chk("R6", "not ready sleeping", qryReady, 0);
    chk("R9", "no err sleep read", offReadErr, 0);
    step();
    chk("R7", "ready after 1", qryReady, 1);
    chk("R7", "reg8 on", {sleepEn[8], offEn[8]}, 2'b00);
    idle();
  endtask

  task automatic testOffWake();
    qryValid = 1; qryWarp = 1; qryWriteMask = 8'h02;
    #1;
    chk("R9", "write off no err", offReadErr, 0);
    chk("R6", "not ready off", qryReady, 0);
    step();
    chk("R8", "waking enables", {sleepEn[9], offEn[9]}, 2'b10);
    chk("R8", "not ready mid", qryReady, 0);
    step();
    chk("R8", "ready after 2", qryReady, 1);
    idle();
  endtask

  task automatic testOffRead();
    wbValid = 1; wbWarp = 1; wbReg = 1; wbHint = 2'b00;
    step(); idle();
    chk("R3", "off hint", {sleepEn[9], offEn[9]}, 2'b01);
    qryValid = 1; qryWarp = 1; qryReadMask = 8'h02;
    #1;
    chk("R9", "off read err", offReadErr, 1);
    step();
    qryValid = 0;
    #1;
    chk("R9", "err needs valid", offReadErr, 0);
    step();
    chk("R8", "woken", qryReady, 1);
    idle();
  endtask

  task automatic testRelease();
    releaseValid = 1; releaseWarp = 1;
    step(); idle();
    chk("R2", "release off", offEn[15:8], 8'hFF);
    allocValid = 1; allocWarp = 1; allocMask = 8'hFF; releaseValid = 1; releaseWarp = 1;
    step(); idle();
    chk("R2", "release wins", offEn[15:8], 8'hFF);
    chk("R2", "no sleep", sleepEn, 0);
  endtask

  task automatic testCounters();
    logic [CW-1:0] on0, sl0, of0;
    on0 = onCycles; sl0 = sleepCycles; of0 = offCycles;
    repeat (5) step();
    chk("R10", "off delta", offCycles - of0, 160);
    chk("R10", "on delta", onCycles - on0, 0);
    allocValid = 1; allocWarp = 2; allocMask = 8'h03;
    step(); idle();
    on0 = onCycles; sl0 = sleepCycles; of0 = offCycles;
    repeat (4) step();
    chk("R10", "on delta", onCycles - on0, 8);
    chk("R10", "off delta", offCycles - of0, 120);
    chk("R10", "sleep delta", sleepCycles - sl0, 0);
  endtask

  initial begin
    #(200_000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    testReset();
    #20 rstN = 1'b1;
    step();
    testAlloc();
    testReadHints();
    testConflict();
    testSleepWake();
    testOffWake();
    testOffRead();
    testRelease();
    testCounters();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule